// File: doc/BRIEF.md
# Quadrature-to-Real Upconverter

The block takes a complex baseband stream, real part and imaginary part of 16 bits each, at one sample every second clock. It interpolates each part by two with a polyphase half-band filter. It then mixes the result with a local oscillator running at a quarter of the output rate, and emits a real stream at the full clock rate.

The oscillator only ever multiplies by 0 or by plus or minus one. Because of that, the block computes just the non-zero products:
- The real part goes through the centre-tap branch of the half-band filter, which is a pure delay. This is the upper leg.
- The imaginary part goes through the symmetric odd-tap branch. This is the lower leg.
- Each leg applies a sign that alternates from one input sample to the next.

The two legs have deliberately different pipeline lengths. A sync input lets the user fix which input sample lines up with the zero-degree cosine.

There are two output modes:
- **Merged mode:** the two legs are interleaved onto port A, one real sample per clock, and port B stays at zero.
- **Split mode:** port A carries the upper leg and port B carries the lower leg. The consumer takes B first, then A, on each clock.

Top module: `q2r_upconv`

## Requirements
- R1: An input sample (`re_i`, `im_i`, `sync_i`) is taken on the first rising edge after reset release and on every second edge after that. Values present on the other edges have no effect on the outputs.
- R2: The upper leg value for input sample n is s·re[n-3], saturated to 16 bits, so that negating -32768 gives +32767. The sign s is +1 when the sample's phase bit is 0 and -1 when it is 1.
- R3: The lower leg value for sample n is -s·(2·Σk c[k]·(im[n-k] + im[n-7+k])) / 2^15, with k running over 0..3, c = {10000, -2300, 650, -158}, and missing history taken as 0.
- R4: Leg results are rounded half-up, by adding 2^13 before an arithmetic right shift of 14, and then clamped to the range [-32768, 32767]. They never wrap.
- R5: If `sync_i` is high when sample n-1 is taken, sample n gets phase bit 0, so its real part meets the zero-degree cosine.
- R6: Without sync, the phase bit is 0 for the first sample after reset and toggles on every sample.
- R7: In split mode (`mux_int_i` = 0), `a_o` shows the upper value of sample n after edges 2n+9 and 2n+10. `b_o` shows the lower value of sample n after edges 2n+26 and 2n+27, where edge 0 is the edge that takes sample 0. On each clock, B is the earlier output sample and A the later one.
- R8: In merged mode (`mux_int_i` = 1), `a_o` after an odd edge k ≥ 15 shows upper value (k-15)/2. After an even edge k ≥ 48 it shows lower value (k-48)/2. `b_o` is 0.
- R9: During reset, and until each leg's pipeline is filled, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, at twice the input sample rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mux_int_i | input | 1 | 1 = merged output on A, 0 = split output on A and B |
| sync_i | input | 1 | Zero-phase request for the next input sample |
| re_i | input | 16 | Real part of the input sample, two's complement |
| im_i | input | 16 | Imaginary part of the input sample, two's complement |
| a_o | output | 16 | Upper leg output, or the merged stream in merged mode |
| b_o | output | 16 | Lower leg output in split mode, otherwise 0 |

## Verification
The embedded assertions check the following on every cycle:
- sync forces phase zero two edges later;
- the phase flips when there is no sync;
- neither leg wraps a positive result to a negative one;
- port B stays quiet in merged mode.

The exact values, which depend on filter arithmetic, rounding and saturation, can only be shown by the bench scenarios. The same holds for the four latencies, the merged interleave order, and the fact that off-edge inputs are ignored. The bench shows these by comparing every output cycle against a reference model built from the requirements.

// File: rtl/q2r_pkg.sv
`timescale 1ns/1ps
package q2r_pkg;
  localparam int DW     = 16;
  localparam int CW     = 16;
  localparam int ACC_W  = 40;
  localparam int N_HALF = 4;              // unique odd-branch taps
  localparam int SHIFT  = CW - 2;         // Q15 plus leg gain of two

  typedef logic signed [DW-1:0]    data_t;
  typedef logic signed [CW-1:0]    coef_t;
  typedef logic signed [ACC_W-1:0] acc_t;
  typedef coef_t coef_set_t [N_HALF];

  localparam coef_set_t COEF_DEF = '{16'sd10000, -16'sd2300, 16'sd650, -16'sd158};
  localparam coef_t     CENTRE   = 16'sd16384;

  localparam acc_t SAT_HI = acc_t'(2**(DW-1) - 1);
  localparam acc_t SAT_LO = -acc_t'(2**(DW-1));
  localparam acc_t RND    = acc_t'(2**(SHIFT-1));

  function automatic data_t rnd_sat(acc_t v);
    acc_t r;
    r = (v + RND) >>> SHIFT;
    if (r > SAT_HI)      return data_t'(SAT_HI);
    else if (r < SAT_LO) return data_t'(SAT_LO);
    else                 return data_t'(r);
  endfunction
endpackage

// File: rtl/q2r_phase.sv
`timescale 1ns/1ps
module q2r_phase (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic acc_o,
  output logic p_used_o
);
  logic cyc_q, ph_q, sync_pend_q;

  assign acc_o    = ~cyc_q;
  assign p_used_o = sync_pend_q ? 1'b0 : ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q       <= 1'b0;
      ph_q        <= 1'b0;
      sync_pend_q <= 1'b0;
    end else begin
      cyc_q <= ~cyc_q;
      if (acc_o) begin
        ph_q        <= ~p_used_o;
        sync_pend_q <= sync_i;
      end
    end
  end

  AST_SYNC_ZERO_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_o && sync_i) |=> ##1 (p_used_o == 1'b0)); // R5

  AST_PHASE_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_o && !sync_i) |=> ##1 (p_used_o != $past(p_used_o, 2))); // R6
endmodule

// File: rtl/q2r_hb_odd.sv
`timescale 1ns/1ps
module q2r_hb_odd
  import q2r_pkg::*;
#(
  parameter coef_set_t COEF = COEF_DEF
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  acc_i,
  input  logic  neg_i,
  input  data_t x_i,
  output data_t y_o
);
  localparam int NW = 2 * N_HALF;

  data_t hist_q [NW-1];
  data_t win [NW];
  acc_t  sum;

  always_comb begin
    win[0] = x_i;
    for (int j = 1; j < NW; j++) win[j] = hist_q[j-1];
    sum = '0;
    for (int k = 0; k < N_HALF; k++)
      sum = sum + acc_t'(COEF[k]) * (acc_t'(win[k]) + acc_t'(win[NW-1-k]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < NW-1; j++) hist_q[j] <= '0;
      y_o <= '0;
    end else if (acc_i) begin
      hist_q[0] <= x_i;
      for (int j = 1; j < NW-1; j++) hist_q[j] <= hist_q[j-1];
      y_o <= rnd_sat(neg_i ? -sum : sum);
    end
  end

  AST_LO_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !neg_i && sum > 0) |=> (y_o >= 0)); // R4
endmodule

// File: rtl/q2r_dly.sv
`timescale 1ns/1ps
module q2r_dly #(
  parameter int W     = 16,
  parameter int TAP_A = 1,   // both taps must be >= 1
  parameter int TAP_B = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] tap_a_o,
  output logic [W-1:0] tap_b_o
);
  localparam int DEPTH = ((TAP_A > TAP_B) ? TAP_A : TAP_B) + 1;

  logic [W-1:0] st_q [1:DEPTH-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 1; j < DEPTH; j++) st_q[j] <= '0;
    end else begin
      st_q[1] <= d_i;
      for (int j = 2; j < DEPTH; j++) st_q[j] <= st_q[j-1];
    end
  end

  assign tap_a_o = st_q[TAP_A];
  assign tap_b_o = st_q[TAP_B];
endmodule

// File: rtl/q2r_upconv.sv
`timescale 1ns/1ps
module q2r_upconv
  import q2r_pkg::*;
#(
  parameter int LAT_UP_INT = 15,   // odd
  parameter int LAT_LO_INT = 48,   // even
  parameter int LAT_UP_EXT = 9,
  parameter int LAT_LO_EXT = 26,
  parameter coef_set_t COEF = COEF_DEF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mux_int_i,
  input  logic          sync_i,
  input  logic [DW-1:0] re_i,
  input  logic [DW-1:0] im_i,
  output logic [DW-1:0] a_o,
  output logic [DW-1:0] b_o
);
  localparam int UP_DLY = N_HALF - 1;   // centre-tap position

  logic  acc, p_used;
  data_t re_hist_q [UP_DLY];
  data_t re_old, u_q, l_q;
  acc_t  up_acc;
  logic [DW-1:0] up_int, up_ext, lo_int, lo_ext;

  q2r_phase u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sync_i   (sync_i),
    .acc_o    (acc),
    .p_used_o (p_used)
  );

  // upper leg: centre tap is a pure delay
  assign re_old = re_hist_q[UP_DLY-1];
  assign up_acc = acc_t'(CENTRE) * acc_t'(re_old);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < UP_DLY; j++) re_hist_q[j] <= '0;
      u_q <= '0;
    end else if (acc) begin
      re_hist_q[0] <= data_t'(re_i);
      for (int j = 1; j < UP_DLY; j++) re_hist_q[j] <= re_hist_q[j-1];
      u_q <= rnd_sat(p_used ? -up_acc : up_acc);
    end
  end

  // lower leg: symmetric odd-tap branch, opposite sign
  q2r_hb_odd #(.COEF(COEF)) u_lo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .acc_i  (acc),
    .neg_i  (~p_used),
    .x_i    (data_t'(im_i)),
    .y_o    (l_q)
  );

  q2r_dly #(.W(DW), .TAP_A(LAT_UP_INT-1), .TAP_B(LAT_UP_EXT-1)) u_dly_up (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .d_i     (u_q),
    .tap_a_o (up_int),
    .tap_b_o (up_ext)
  );

  q2r_dly #(.W(DW), .TAP_A(LAT_LO_INT-1), .TAP_B(LAT_LO_EXT-1)) u_dly_lo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .d_i     (l_q),
    .tap_a_o (lo_int),
    .tap_b_o (lo_ext)
  );

  // merged: upper on edges between accepts, lower on accept edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_o <= '0;
      b_o <= '0;
    end else if (mux_int_i) begin
      a_o <= acc ? lo_int : up_int;
      b_o <= '0;
    end else begin
      a_o <= up_ext;
      b_o <= lo_ext;
    end
  end

  AST_UP_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !p_used && re_old > 0) |=> ($signed(u_q) > 0)); // R2

  AST_INT_B_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mux_int_i && $past(mux_int_i)) |-> (b_o == '0)); // R8
endmodule

// File: tb/sim_q2r_upconv.sv
`timescale 1ns/1ps
module sim_q2r_upconv;
  localparam int NA = 128;
  localparam int C [4] = '{10000, -2300, 650, -158};

  logic clk = 1'b0;
  logic rst_ni, mux_int, sync;
  logic [15:0] re, im, a, b;
  int n_chk = 0, n_fail = 0;
  int s_re [NA], s_im [NA], u_ref [NA], l_ref [NA];
  bit s_sync [NA];

  always #10 clk = ~clk;   // 50 MHz

  q2r_upconv u0 (
    .clk_i(clk), .rst_ni(rst_ni), .mux_int_i(mux_int), .sync_i(sync),
    .re_i(re), .im_i(im), .a_o(a), .b_o(b)
  );

  function automatic int rs(longint v);
    longint r;
    r = (v + 8192) >>> 14;
    if (r > 32767) return 32767;
    if (r < -32768) return -32768;
    return int'(r);
  endfunction

  task automatic check(string tag, int k, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s edge %0d: actual %0d expected %0d", tag, k, act, exp);
    end
  endtask

  task automatic clr();
    for (int i = 0; i < NA; i++) begin
      s_re[i] = 0; s_im[i] = 0; s_sync[i] = 1'b0;
    end
  endtask

  task automatic build_ref();
    int p = 0;
    for (int n = 0; n < NA; n++) begin
      int pu;
      longint v, s;
      pu = (n > 0 && s_sync[n-1]) ? 0 : p;   // R5, R6
      p  = 1 - pu;
      v  = 16384 * longint'((n >= 3) ? s_re[n-3] : 0);
      u_ref[n] = rs(pu != 0 ? -v : v);
      s = 0;
      for (int k = 0; k < 4; k++) begin
        int x0, x1;
        x0 = (n - k >= 0) ? s_im[n-k] : 0;
        x1 = (n - 7 + k >= 0) ? s_im[n-7+k] : 0;
        s += longint'(C[k]) * longint'(x0 + x1);
      end
      l_ref[n] = rs(pu != 0 ? s : -s);
    end
  endtask

  task automatic run_case(string tag, bit mode, int ns);
    int kmax;
    kmax = 2 * ns + 56;
    build_ref();
    rst_ni = 1'b0; mux_int = mode; sync = 1'b0; re = '0; im = '0;
    repeat (3) @(negedge clk);
    check({tag, " R9 reset A"}, -1, int'($signed(a)), 0);
    check({tag, " R9 reset B"}, -1, int'($signed(b)), 0);
    rst_ni = 1'b1;
    for (int k = 0; k < kmax; k++) begin
      int ea, eb;
      if (k % 2 == 0) begin
        re = 16'(s_re[k/2]); im = 16'(s_im[k/2]); sync = s_sync[k/2];
      end else begin   // R1: junk between accept edges
        re = 16'h5A5A; im = 16'hC3C4; sync = 1'b1;
      end
      @(posedge clk);
      @(negedge clk);
      if (mode) begin
        if (k % 2 == 1) ea = (k >= 15) ? u_ref[(k-15)/2] : 0;
        else            ea = (k >= 48) ? l_ref[(k-48)/2] : 0;
        eb = 0;
      end else begin
        ea = (k >= 9)  ? u_ref[(k-9)/2]  : 0;
        eb = (k >= 26) ? l_ref[(k-26)/2] : 0;
      end
      check({tag, " A"}, k, int'($signed(a)), ea);
      check({tag, " B"}, k, int'($signed(b)), eb);
    end
  endtask

  task automatic t_const_split();
    clr();
    for (int n = 0; n < 30; n++) begin s_re[n] = 1000; s_im[n] = -700; end
    run_case("R1/R2/R3/R7 const split", 1'b0, 30);
  endtask

  task automatic t_tone_merged();
    clr();
    for (int n = 0; n < 40; n++) begin
      s_re[n] = (n % 8 - 4) * 3000 + n * 37;
      s_im[n] = 5000 - (n % 5) * 2100;
    end
    run_case("R2/R3/R8 tone merged", 1'b1, 40);
  endtask

  task automatic t_sync();
    clr();
    for (int n = 0; n < 30; n++) begin s_re[n] = 1200 + n * 50; s_im[n] = -900 + n * 20; end
    s_sync[0] = 1'b1; s_sync[4] = 1'b1; s_sync[11] = 1'b1; s_sync[12] = 1'b1;
    run_case("R5/R6 sync split", 1'b0, 30);
    run_case("R5/R8 sync merged", 1'b1, 30);
  endtask

  task automatic t_sat();
    int sg [8] = '{1, -1, 1, -1, -1, 1, -1, 1};
    clr();
    for (int n = 0; n < 32; n++) begin
      s_re[n] = (n < 16) ? -32768 : 32767;
      s_im[n] = sg[7 - n % 8] * 32767;
    end
    run_case("R4/R2 saturate split", 1'b0, 32);
    run_case("R4 saturate merged", 1'b1, 32);
  endtask

  initial begin
    t_const_split();
    t_tone_merged();
    t_sync();
    t_sat();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule